// File: doc/BRIEF.md
# Virtual Output Queue Bank for a Switch Input Stage

This block is the cell buffer of one first-stage module in a three-stage switching fabric. It has a configurable number of input ports, each able to present one fixed-width cell per slot (one clock cycle). Each cell carries the number of its destination output module and the port within that module. The cell is filed into one of `N_PORTS * N_MODS` virtual output queues. Any number of input ports may hit the same queue in one slot, and every cell that fits is appended without loss of order.

An external dispatcher reads the exported per-queue occupancy counts and non-empty flags. Each slot it presents up to `N_LINKS` grants, one per output link, and each grant names a queue. For every honoured grant the bank pops the head cell of that queue and drives it on that link in the next cycle. Storage is a fixed segment of `DEPTH` cells per queue, managed as a circular buffer.

On the input side, `in_ready` is advisory and combinational. A cell presented with `in_valid` high while its `in_ready` is low is not held back. It is discarded, and `drop` pulses for that port in the same cycle. The output links have no back-pressure: a link whose `out_valid` is high carries a committed cell for exactly one cycle.

Top module: `voq_bank`

## Requirements
- R1: A cell whose destination module field is j and whose destination port field is h is stored in queue `h*N_MODS + j`.
- R2: When several input ports write the same queue in one slot, the cells are appended in ascending input-port order, and they later leave in that order.
- R3: A cell that finds its queue without room is discarded. In that same cycle its port shows `in_ready` low and `drop` high, and the queue count never exceeds `DEPTH`.
- R4: Room is judged on the occupancy at the start of the slot plus the accepted cells of lower-numbered ports to the same queue. A dequeue in the same slot does not free room for that slot.
- R5: A cell written in a slot cannot be dequeued before the next slot. A grant to a queue that is empty at the start of the slot yields no output, even when cells are written to that queue in that slot.
- R6: A grant on link r to a non-empty queue v makes `out_valid[r]` high one cycle later, with `out_cell` equal to v's head cell and `out_queue` equal to v. That cell is then removed from v.
- R7: When several links grant the same queue in one slot, only the lowest-numbered link is served. The others show `out_valid` low and no extra cell is removed.
- R8: A grant to an empty queue leaves that link's `out_valid` low and the queue unchanged.
- R9: Different links granting different non-empty queues are all served in the same slot.
- R10: After each clock edge, `q_count[v]` equals the previous count plus the cells accepted into v minus the cell (at most one) dequeued from v. `q_nonempty[v]` is high exactly when that count is non-zero.
- R11: After reset, all queues are empty, every `out_valid` is low, and every `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Cell present on each input port |
| in_ready | output | N_PORTS | Cell on this port would be accepted this slot |
| in_cell | input | N_PORTS*CELL_W | Cell payload per port |
| in_mod | input | N_PORTS*JW | Destination output module per port |
| in_port | input | N_PORTS*HW | Destination port within that module |
| drop | output | N_PORTS | Cell on this port discarded this slot |
| gnt_valid | input | N_LINKS | Grant present on each output link |
| gnt_queue | input | N_LINKS*QW | Queue index granted to each link |
| out_valid | output | N_LINKS | Link carries a dequeued cell |
| out_cell | output | N_LINKS*CELL_W | Dequeued cell per link |
| out_queue | output | N_LINKS*QW | Queue the link's cell came from |
| q_nonempty | output | NQ | Per-queue non-empty flag |
| q_count | output | NQ*CW | Per-queue occupancy count |

## Verification
The timing of each result fixes where the bench samples it:
- `in_ready` and `drop` are combinational and are due in the same cycle the cell is presented. The bench reads them a short delay after driving the inputs and before the clock edge.
- Counts and non-empty flags change at the edge that ends the slot.
- Dequeued cells appear on the link one edge after the grant.

Both kinds of registered result are therefore read at the falling edge after that rising edge. Tests that mix an enqueue and a grant in one slot pin down the next-slot eligibility rule and the start-of-slot room rule.

// File: rtl/voq_pkg.sv
package voq_pkg;
  // Queue index for destination port h within output module j
  function automatic int voq_index(int h, int j, int n_mods);
    return h * n_mods + j;
  endfunction
endpackage

// File: rtl/voq_enq_rank.sv
module voq_enq_rank #(
  parameter int N_PORTS = 4,
  parameter int N_MODS  = 2,
  parameter int DEPTH   = 4,
  parameter int JW      = 1,
  parameter int HW      = 2,
  parameter int QW      = 3,
  parameter int CW      = 3,
  parameter int RW      = 3,
  parameter int NQ      = N_PORTS * N_MODS
) (
  input  logic [N_PORTS-1:0]    in_valid,
  input  logic [N_PORTS*JW-1:0] in_mod,
  input  logic [N_PORTS*HW-1:0] in_port,
  input  logic [NQ*CW-1:0]      occ_flat,
  output logic [N_PORTS-1:0]    room,
  output logic [N_PORTS-1:0]    accept,
  output logic [N_PORTS*QW-1:0] wq,
  output logic [N_PORTS*RW-1:0] wrank
);
  int qi [N_PORTS];
  int rk [N_PORTS];

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      qi[p] = voq_pkg::voq_index(int'(in_port[p*HW +: HW]), int'(in_mod[p*JW +: JW]), N_MODS);
    end
    for (int p = 0; p < N_PORTS; p++) begin
      rk[p] = 0;
      for (int i = 0; i < p; i++) begin
        if (in_valid[i] && qi[i] == qi[p]) rk[p] = rk[p] + 1;
      end
    end
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic [CW-1:0] occ_here;
    assign occ_here = occ_flat[qi[g]*CW +: CW];
    assign room[g]   = (int'(occ_here) + rk[g]) < DEPTH;
    assign accept[g] = in_valid[g] && room[g];
    assign wq[g*QW +: QW]    = QW'(qi[g]);
    assign wrank[g*RW +: RW] = RW'(rk[g]);
  end
endmodule

// File: rtl/voq_grant_pick.sv
module voq_grant_pick #(
  parameter int N_LINKS = 3,
  parameter int NQ      = 8,
  parameter int QW      = 3
) (
  input  logic [N_LINKS-1:0]    gnt_valid,
  input  logic [N_LINKS*QW-1:0] gnt_queue,
  input  logic [NQ-1:0]         nonempty,
  output logic [N_LINKS-1:0]    take,
  output logic [NQ-1:0]         deq_mask
);
  always_comb begin
    deq_mask = '0;
    take     = '0;
    for (int r = 0; r < N_LINKS; r++) begin
      int gq;
      gq = int'(gnt_queue[r*QW +: QW]);
      if (gnt_valid[r] && gq < NQ) begin
        if (nonempty[gq] && !deq_mask[gq]) begin
          take[r]      = 1'b1;
          deq_mask[gq] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/voq_store.sv
module voq_store #(
  parameter int N_PORTS = 4,
  parameter int N_LINKS = 3,
  parameter int NQ      = 8,
  parameter int CELL_W  = 8,
  parameter int DEPTH   = 4,
  parameter int QW      = 3,
  parameter int RW      = 3,
  parameter int CW      = 3,
  parameter int PW      = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        accept,
  input  logic [N_PORTS*QW-1:0]     wq,
  input  logic [N_PORTS*RW-1:0]     wrank,
  input  logic [N_PORTS*CELL_W-1:0] wcell,
  input  logic [N_LINKS-1:0]        take,
  input  logic [N_LINKS*QW-1:0]     gq,
  input  logic [NQ-1:0]             deq_mask,
  output logic [NQ*CW-1:0]          occ_flat,
  output logic [NQ-1:0]             nonempty,
  output logic [N_LINKS-1:0]        out_valid,
  output logic [N_LINKS*CELL_W-1:0] out_cell,
  output logic [N_LINKS*QW-1:0]     out_queue
);
  logic [CELL_W-1:0] mem  [NQ*DEPTH];
  logic [PW-1:0]     head [NQ];
  logic [CW-1:0]     occ  [NQ];
  int                cnt  [NQ];
  int                waddr [N_PORTS];
  logic [CELL_W-1:0] rdata [N_LINKS];

  always_comb begin
    for (int v = 0; v < NQ; v++) begin
      cnt[v] = 0;
      for (int p = 0; p < N_PORTS; p++) begin
        if (accept[p] && int'(wq[p*QW +: QW]) == v) cnt[v] = cnt[v] + 1;
      end
    end
    for (int p = 0; p < N_PORTS; p++) begin
      int v;
      logic [PW-1:0] ptr;
      v = int'(wq[p*QW +: QW]);
      if (v >= NQ) v = 0;
      ptr = PW'(int'(head[v]) + int'(occ[v]) + int'(wrank[p*RW +: RW]));
      waddr[p] = v * DEPTH + int'(ptr);
    end
    for (int r = 0; r < N_LINKS; r++) begin
      int v;
      v = int'(gq[r*QW +: QW]);
      if (v >= NQ) v = 0;
      rdata[r] = mem[v * DEPTH + int'(head[v])];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < N_PORTS; p++) begin
      if (accept[p]) mem[waddr[p]] <= wcell[p*CELL_W +: CELL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NQ; v++) begin
        head[v] <= '0;
        occ[v]  <= '0;
      end
      out_valid <= '0;
      out_cell  <= '0;
      out_queue <= '0;
    end else begin
      for (int v = 0; v < NQ; v++) begin
        head[v] <= head[v] + PW'(deq_mask[v]);
        occ[v]  <= CW'(int'(occ[v]) + cnt[v] - int'(deq_mask[v]));
      end
      out_valid <= take;
      for (int r = 0; r < N_LINKS; r++) begin
        out_cell[r*CELL_W +: CELL_W] <= rdata[r];
        out_queue[r*QW +: QW]        <= gq[r*QW +: QW];
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign occ_flat[g*CW +: CW] = occ[g];
    assign nonempty[g]          = occ[g] != '0;
  end
endmodule

// File: rtl/voq_bank.sv
module voq_bank #(
  parameter int N_PORTS = 4,
  parameter int N_MODS  = 2,
  parameter int N_LINKS = 3,
  parameter int DEPTH   = 4,
  parameter int CELL_W  = 8,
  localparam int NQ = N_PORTS * N_MODS,
  localparam int JW = (N_MODS > 1) ? $clog2(N_MODS) : 1,
  localparam int HW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RW = $clog2(N_PORTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        in_valid,
  output logic [N_PORTS-1:0]        in_ready,
  input  logic [N_PORTS*CELL_W-1:0] in_cell,
  input  logic [N_PORTS*JW-1:0]     in_mod,
  input  logic [N_PORTS*HW-1:0]     in_port,
  output logic [N_PORTS-1:0]        drop,
  input  logic [N_LINKS-1:0]        gnt_valid,
  input  logic [N_LINKS*QW-1:0]     gnt_queue,
  output logic [N_LINKS-1:0]        out_valid,
  output logic [N_LINKS*CELL_W-1:0] out_cell,
  output logic [N_LINKS*QW-1:0]     out_queue,
  output logic [NQ-1:0]             q_nonempty,
  output logic [NQ*CW-1:0]          q_count
);
  logic [N_PORTS-1:0]    accept;
  logic [N_PORTS*QW-1:0] wq;
  logic [N_PORTS*RW-1:0] wrank;
  logic [N_LINKS-1:0]    take;
  logic [NQ-1:0]         deq_mask;

  voq_enq_rank #(
    .N_PORTS(N_PORTS), .N_MODS(N_MODS), .DEPTH(DEPTH), .JW(JW), .HW(HW),
    .QW(QW), .CW(CW), .RW(RW), .NQ(NQ)
  ) u_rank (
    .in_valid(in_valid), .in_mod(in_mod), .in_port(in_port), .occ_flat(q_count),
    .room(in_ready), .accept(accept), .wq(wq), .wrank(wrank)
  );

  voq_grant_pick #(.N_LINKS(N_LINKS), .NQ(NQ), .QW(QW)) u_pick (
    .gnt_valid(gnt_valid), .gnt_queue(gnt_queue), .nonempty(q_nonempty),
    .take(take), .deq_mask(deq_mask)
  );

  voq_store #(
    .N_PORTS(N_PORTS), .N_LINKS(N_LINKS), .NQ(NQ), .CELL_W(CELL_W), .DEPTH(DEPTH),
    .QW(QW), .RW(RW), .CW(CW), .PW(PW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wq(wq), .wrank(wrank), .wcell(in_cell),
    .take(take), .gq(gnt_queue), .deq_mask(deq_mask), .occ_flat(q_count),
    .nonempty(q_nonempty), .out_valid(out_valid), .out_cell(out_cell), .out_queue(out_queue)
  );

  assign drop = in_valid & ~in_ready;
endmodule

// File: rtl/voq_bank_chk.sv
module voq_bank_chk #(
  parameter int N_PORTS = 4,
  parameter int N_MODS  = 2,
  parameter int N_LINKS = 3,
  parameter int DEPTH   = 4,
  parameter int NQ      = 8,
  parameter int QW      = 3,
  parameter int CW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PORTS-1:0] in_valid,
  input logic [N_PORTS-1:0] in_ready,
  input logic [N_PORTS-1:0] drop,
  input logic [N_LINKS-1:0] gnt_valid,
  input logic [N_LINKS*QW-1:0] gnt_queue,
  input logic [N_LINKS-1:0] out_valid,
  input logic [N_LINKS*QW-1:0] out_queue,
  input logic [NQ-1:0]      q_nonempty,
  input logic [NQ*CW-1:0]   q_count
);
  for (genvar v = 0; v < NQ; v++) begin : g_q
    p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count[v*CW +: CW]) <= DEPTH);
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count[v*CW +: CW]) <= int'($past(q_count[v*CW +: CW])) + N_PORTS);
  end
  for (genvar p = 0; p < N_PORTS; p++) begin : g_p
    p_drop_needs_cell_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drop[p] |-> (in_valid[p] && !in_ready[p]));
  end
  for (genvar r = 0; r < N_LINKS; r++) begin : g_r
    p_out_from_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[r] |-> $past(gnt_valid[r]));
    p_empty_grant_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid[r] && !q_nonempty[gnt_queue[r*QW +: QW]]) |=> !out_valid[r]);
    for (genvar s = r + 1; s < N_LINKS; s++) begin : g_s
      p_unique_queue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[r] && out_valid[s]) |-> (out_queue[r*QW +: QW] != out_queue[s*QW +: QW]));
    end
  end
endmodule

bind voq_bank voq_bank_chk #(
  .N_PORTS(N_PORTS), .N_MODS(N_MODS), .N_LINKS(N_LINKS), .DEPTH(DEPTH),
  .NQ(NQ), .QW(QW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .drop(drop),
  .gnt_valid(gnt_valid), .gnt_queue(gnt_queue), .out_valid(out_valid),
  .out_queue(out_queue), .q_nonempty(q_nonempty), .q_count(q_count)
);

// File: tb/voq_bank_tb.sv
module voq_bank_tb;
  localparam int N = 4, K = 2, M = 3, D = 4, W = 8;
  localparam int NQ = N * K, JW = 1, HW = 2, QW = 3, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] in_valid, in_ready, drop;
  logic [N*W-1:0] in_cell;
  logic [N*JW-1:0] in_mod;
  logic [N*HW-1:0] in_port;
  logic [M-1:0] gnt_valid, out_valid;
  logic [M*QW-1:0] gnt_queue, out_queue;
  logic [M*W-1:0] out_cell;
  logic [NQ-1:0] q_nonempty;
  logic [NQ*CW-1:0] q_count;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  voq_bank #(.N_PORTS(N), .N_MODS(K), .N_LINKS(M), .DEPTH(D), .CELL_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_cell(in_cell),
    .in_mod(in_mod), .in_port(in_port), .drop(drop), .gnt_valid(gnt_valid),
    .gnt_queue(gnt_queue), .out_valid(out_valid), .out_cell(out_cell),
    .out_queue(out_queue), .q_nonempty(q_nonempty), .q_count(q_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cnt_of(input int v);
    return int'(q_count[v*CW +: CW]);
  endfunction

  function automatic int cell_of(input int r);
    return int'(out_cell[r*W +: W]);
  endfunction

  task automatic idle();
    in_valid = '0; in_cell = '0; in_mod = '0; in_port = '0;
    gnt_valid = '0; gnt_queue = '0;
  endtask

  task automatic put(input int p, input int j, input int h, input int c);
    in_valid[p] = 1'b1;
    in_cell[p*W +: W] = W'(c);
    in_mod[p*JW +: JW] = JW'(j);
    in_port[p*HW +: HW] = HW'(h);
  endtask

  task automatic grant(input int r, input int v);
    gnt_valid[r] = 1'b1;
    gnt_queue[r*QW +: QW] = QW'(v);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic pop_expect(input int r, input int v, input int c, input string tag);
    grant(r, v);
    step();
    chk(out_valid[r] == 1'b1, tag, int'(out_valid[r]), 1);
    chk(cell_of(r) == c, tag, cell_of(r), c);
    chk(int'(out_queue[r*QW +: QW]) == v, tag, int'(out_queue[r*QW +: QW]), v);
  endtask

  task automatic t_reset();
    chk(q_count == '0, "R11 counts", int'(q_count), 0);
    chk(q_nonempty == '0, "R11 nonempty", int'(q_nonempty), 0);
    chk(out_valid == '0, "R11 out_valid", int'(out_valid), 0);
    chk(in_ready == '1, "R11 in_ready", int'(in_ready), 15);
  endtask

  task automatic t_mapping();
    put(0, 1, 2, 8'h5A);                 // R1: h=2, j=1 -> queue 5
    step();
    chk(cnt_of(5) == 1, "R1 count q5", cnt_of(5), 1);
    chk(q_nonempty == 8'h20, "R10 nonempty", int'(q_nonempty), 32);
    pop_expect(0, 5, 8'h5A, "R6 head");
    chk(cnt_of(5) == 0, "R6 removed", cnt_of(5), 0);
  endtask

  task automatic t_burst();
    for (int p = 0; p < N; p++) put(p, 1, 1, 8'hA0 + p);  // queue 3
    grant(0, 3);                          // R5: empty at slot start
    step();
    chk(out_valid[0] == 1'b0, "R5 same-slot grant", int'(out_valid[0]), 0);
    chk(cnt_of(3) == 4, "R2 count", cnt_of(3), 4);
    for (int i = 0; i < N; i++) begin
      pop_expect(1, 3, 8'hA0 + i, "R2 order");
      chk(cnt_of(3) == 3 - i, "R10 drain", cnt_of(3), 3 - i);
    end
  endtask

  task automatic t_full();
    for (int p = 0; p < 3; p++) put(p, 0, 0, 8'h30 + p);  // queue 0
    step();
    put(0, 0, 0, 8'h40);
    put(1, 0, 0, 8'h41);
    #1;
    chk(in_ready[0] == 1'b1, "R3 room last slot", int'(in_ready[0]), 1);
    chk(in_ready[1] == 1'b0, "R3 no room", int'(in_ready[1]), 0);
    chk(drop[1] == 1'b1, "R3 drop pulse", int'(drop[1]), 1);
    step();
    chk(cnt_of(0) == 4, "R3 capped", cnt_of(0), 4);
    put(0, 0, 0, 8'hEE);
    grant(0, 0);
    #1;
    chk(in_ready[0] == 1'b0, "R4 deq frees nothing", int'(in_ready[0]), 0);
    chk(drop[0] == 1'b1, "R4 drop", int'(drop[0]), 1);
    step();
    chk(out_valid[0] && cell_of(0) == 8'h30, "R4 head out", cell_of(0), 8'h30);
    chk(cnt_of(0) == 3, "R4 count", cnt_of(0), 3);
    pop_expect(2, 0, 8'h31, "R3 order");
    pop_expect(2, 0, 8'h32, "R3 order");
    pop_expect(2, 0, 8'h40, "R3 order");
    chk(q_nonempty[0] == 1'b0, "R10 empty", int'(q_nonempty[0]), 0);
  endtask

  task automatic t_links();
    put(0, 1, 0, 8'h11);                  // queue 1
    put(1, 0, 1, 8'h22);                  // queue 2
    step();
    grant(0, 1); grant(1, 1); grant(2, 2);
    step();
    chk(out_valid == 3'b101, "R7 dup grant", int'(out_valid), 5);
    chk(cell_of(0) == 8'h11, "R9 link0", cell_of(0), 8'h11);
    chk(cell_of(2) == 8'h22, "R9 link2", cell_of(2), 8'h22);
    chk(cnt_of(1) == 0 && cnt_of(2) == 0, "R7 one removed", cnt_of(1) + cnt_of(2), 0);
  endtask

  task automatic t_empty();
    grant(2, 7);
    step();
    chk(out_valid[2] == 1'b0, "R8 empty grant", int'(out_valid[2]), 0);
    chk(cnt_of(7) == 0, "R8 unchanged", cnt_of(7), 0);
  endtask

  task automatic t_mixed();
    put(0, 0, 2, 8'h60); put(1, 0, 2, 8'h61);  // queue 4
    step();
    put(2, 0, 2, 8'h62); put(3, 0, 2, 8'h63);
    grant(1, 4);
    step();
    chk(out_valid[1] && cell_of(1) == 8'h60, "R10 mixed head", cell_of(1), 8'h60);
    chk(cnt_of(4) == 3, "R10 mixed count", cnt_of(4), 3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_mapping();
    t_burst();
    t_full();
    t_links();
    t_empty();
    t_mixed();
    finish_run();
  end
endmodule